// File: doc/BRIEF.md
# Lossy Trigger-Record FIFO Writer

On every level-1 accept strobe, this block packs the current event number and bunch-crossing number into one 64-bit trigger record. It then places the record in an on-block synchronous FIFO. The trigger source is never held back. If the FIFO will be full in the cycle the record would be written, the record is thrown away and a saturating drop counter records the loss. No retry is made.

A downstream link controller drains the FIFO through a show-ahead read port: the head word is always visible, and a read strobe pops it. The registered write strobe and the write data are also brought out to the ports, so each record can be seen at the moment it enters the FIFO.

Top module: `trig_record_writer`

## Requirements
- R1: After reset, `fifo_wr_o` is 0, `drop_count_o` is 0, `fifo_empty_o` is 1 and `fifo_full_o` is 0.
- R2: A record has this layout: the crossing number is in bits 11:0, event-number bits 19:0 are in bits 31:12, and bits 63:32 are zero.
- R3: An accept that is kept raises `fifo_wr_o` for exactly one clock, on the cycle after the strobe, with the record on `fifo_wdata_o`. Back-to-back accepts give back-to-back write cycles.
- R4: When `accept_i` is low, the event and crossing inputs have no effect: no write occurs and the FIFO stays unchanged.
- R5: The FIFO holds 1024 words. It returns them in write order through `fifo_rdata_o`, and `fifo_rd_i` pops the head word when the FIFO is not empty.
- R6: The full check uses the FIFO state in the cycle the write would occur. When the FIFO is full and no read happens in the accept cycle, the record is dropped, no write is issued, and the FIFO contents are unchanged.
- R7: A read in the same cycle as an accept on a full FIFO frees a slot, so that record is kept. While the FIFO is full, a write cycle is refused even if a read happens in that cycle.
- R8: Each dropped record adds one to the 16-bit `drop_count_o`. The counter holds at 65535 and does not wrap.
- R9: `drop_clr_i` sets `drop_count_o` to zero on the next clock. Clearing takes priority over a drop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | Level-1 accept strobe, one cycle per trigger |
| evt_num_i | input | 20 | Event number |
| bx_num_i | input | 12 | Bunch-crossing number |
| drop_clr_i | input | 1 | Synchronous clear of the drop counter |
| fifo_rd_i | input | 1 | Pop the head FIFO word |
| fifo_wr_o | output | 1 | Registered FIFO write strobe |
| fifo_wdata_o | output | 64 | Registered record being written |
| fifo_rdata_o | output | 64 | Head word of the FIFO (show-ahead) |
| fifo_empty_o | output | 1 | FIFO holds no words |
| fifo_full_o | output | 1 | FIFO holds 1024 words |
| drop_count_o | output | 16 | Saturating count of discarded records |

## Verification
The bench first sends a single accept with distinct event and crossing values. This separates the field positions and shows the zero upper half. It then sends a burst of back-to-back accepts and reads the words back, which shows that consecutive writes are neither merged nor reordered. A long run of accepts fills the FIFO to exactly 1024 words and then goes past that point. This shows the boundary between the last record kept and the first record dropped. On the full FIFO, the bench places a read in the same cycle as an accept, and then one cycle after an accept. Only the first of these placements may keep the record. Finally, the bench clears the counter while drops are happening and drives more than 65535 drops, which shows both the clear priority and saturation rather than wrap-around.

// File: rtl/trig_rec_pkg.sv
package trig_rec_pkg;
  localparam int EVN_W  = 20;
  localparam int BXN_W  = 12;
  localparam int WORD_W = 64;
  localparam int CNT_W  = 16;
  localparam int DEPTH  = 1024;

  typedef struct packed {
    logic [WORD_W-EVN_W-BXN_W-1:0] pad;
    logic [EVN_W-1:0]              evn;
    logic [BXN_W-1:0]              bxn;
  } trig_rec_t;
endpackage

// File: rtl/rec_pack.sv
module rec_pack
  import trig_rec_pkg::*;
(
  input  logic [EVN_W-1:0]  evn_i,
  input  logic [BXN_W-1:0]  bxn_i,
  output logic [WORD_W-1:0] word_o
);
  trig_rec_t rec;

  always_comb begin
    rec.pad = '0;
    rec.evn = evn_i;
    rec.bxn = bxn_i;
    word_o  = rec;
  end
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         full_next_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, empty_q;
  logic          wr_ok, rd_ok;

  always_comb begin
    wr_ok  = wr_i & ~full_q;
    rd_ok  = rd_i & ~empty_q;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_ok) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (rd_ok) rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    cnt_d = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    full_next_o = (cnt_d == CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      full_q  <= full_next_o;
      empty_q <= (cnt_d == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem[rptr_q];
  assign empty_o = empty_q;
  assign full_o  = full_q;

  // R5: occupancy never exceeds the depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: a write presented while full leaves the occupancy untouched by it
  assert_full_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && wr_i && !rd_i) |=> full_q && $stable(wptr_q));
  // R5: a pop on empty is ignored
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && rd_i && !wr_i) |=> empty_q && $stable(rptr_q));
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q != MAXV));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R8: holds at the top value
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr_i) |=> cnt_q == MAXV);
  // R9: clear wins
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
  // R8: never moves by more than one without a clear
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/trig_record_writer.sv
module trig_record_writer
  import trig_rec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [EVN_W-1:0]  evt_num_i,
  input  logic [BXN_W-1:0]  bx_num_i,
  input  logic              drop_clr_i,
  input  logic              fifo_rd_i,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_wdata_o,
  output logic [WORD_W-1:0] fifo_rdata_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o,
  output logic [CNT_W-1:0]  drop_count_o
);
  logic [WORD_W-1:0] rec_word;
  logic              full_next;
  logic              keep, drop;
  logic              wr_q, wr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;

  rec_pack u_pack (
    .evn_i  (evt_num_i),
    .bxn_i  (bx_num_i),
    .word_o (rec_word)
  );

  always_comb begin
    keep    = accept_i & ~full_next;
    drop    = accept_i &  full_next;
    wr_d    = keep;
    wdata_d = rec_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wdata_q <= '0;
    else if (keep) wdata_q <= wdata_d;
  end

  rec_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (wr_q),
    .wdata_i     (wdata_q),
    .rd_i        (fifo_rd_i),
    .rdata_o     (fifo_rdata_o),
    .empty_o     (fifo_empty_o),
    .full_o      (fifo_full_o),
    .full_next_o (full_next)
  );

  drop_counter #(.CW(CNT_W)) u_drop (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (drop_clr_i),
    .inc_i   (drop),
    .count_o (drop_count_o)
  );

  assign fifo_wr_o    = wr_q;
  assign fifo_wdata_o = wdata_q;

  // R3: every write stems from an accept one cycle earlier
  assert_wr_from_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(accept_i));
  // R6: the writer never presents a word to a full FIFO
  assert_wr_not_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> !fifo_full_o);
  // R2: upper half of a written record is zero
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> fifo_wdata_o[WORD_W-1:EVN_W+BXN_W] == '0);
  // R4: no accept, no write on the next cycle
  assert_idle_no_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> !wr_q);
endmodule

// File: tb/sim_trig_record_writer.sv
module sim_trig_record_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_i = 1'b0;
  logic [19:0] evt_num_i = '0;
  logic [11:0] bx_num_i = '0;
  logic        drop_clr_i = 1'b0;
  logic        fifo_rd_i = 1'b0;
  logic        fifo_wr_o;
  logic [63:0] fifo_wdata_o, fifo_rdata_o;
  logic        fifo_empty_o, fifo_full_o;
  logic [15:0] drop_count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_record_writer u0 (.*);

  function automatic logic [63:0] mk(input logic [19:0] e, input logic [11:0] b);
    return {32'h0, e, b};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wr", 64'(fifo_wr_o), 64'd0);
    chk("R1 drop", 64'(drop_count_o), 64'd0);
    chk("R1 empty", 64'(fifo_empty_o), 64'd1);
    chk("R1 full", 64'(fifo_full_o), 64'd0);
  endtask

  task automatic t_single();
    accept_i = 1; evt_num_i = 20'hABCDE; bx_num_i = 12'h123;
    step();
    accept_i = 0;
    chk("R3 wr pulse", 64'(fifo_wr_o), 64'd1);
    chk("R2 format", fifo_wdata_o, 64'h00000000_ABCDE123);
    step();
    chk("R3 one clock", 64'(fifo_wr_o), 64'd0);
    chk("R5 head", fifo_rdata_o, 64'h00000000_ABCDE123);
    fifo_rd_i = 1; step(); fifo_rd_i = 0;
    chk("R5 empty after pop", 64'(fifo_empty_o), 64'd1);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      evt_num_i = 20'(i * 7 + 3); bx_num_i = 12'(i * 11);
      step();
      chk("R4 no write", 64'(fifo_wr_o), 64'd0);
    end
    chk("R4 still empty", 64'(fifo_empty_o), 64'd1);
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++) begin
      accept_i = 1; evt_num_i = 20'h10 + 20'(i); bx_num_i = 12'hF00 + 12'(i);
      step();
      chk("R3 burst wr", 64'(fifo_wr_o), 64'd1);
      chk("R3 burst data", fifo_wdata_o, mk(20'h10 + 20'(i), 12'hF00 + 12'(i)));
    end
    accept_i = 0;
    step();
    for (int i = 0; i < 4; i++) begin
      chk("R5 order", fifo_rdata_o, mk(20'h10 + 20'(i), 12'hF00 + 12'(i)));
      fifo_rd_i = 1; step(); fifo_rd_i = 0;
    end
    chk("R5 drained", 64'(fifo_empty_o), 64'd1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 1024; i++) begin
      accept_i = 1; evt_num_i = 20'(i); bx_num_i = 12'(i);
      step();
    end
    accept_i = 0;
    step();
    chk("R5 full at 1024", 64'(fifo_full_o), 64'd1);
    chk("R6 no drop yet", 64'(drop_count_o), 64'd0);
    for (int i = 0; i < 3; i++) begin
      accept_i = 1; evt_num_i = 20'hFFFFF; bx_num_i = 12'hFFF;
      step();
      chk("R6 dropped no write", 64'(fifo_wr_o), 64'd0);
    end
    accept_i = 0;
    chk("R8 drop count", 64'(drop_count_o), 64'd3);
    chk("R6 head unchanged", fifo_rdata_o, mk(20'd0, 12'd0));
  endtask

  task automatic t_same_cycle();
    accept_i = 1; fifo_rd_i = 1; evt_num_i = 20'h55555; bx_num_i = 12'h555;
    step();
    accept_i = 0; fifo_rd_i = 0;
    chk("R7 kept wr", 64'(fifo_wr_o), 64'd1);
    chk("R7 no drop", 64'(drop_count_o), 64'd3);
    chk("R7 next head", fifo_rdata_o, mk(20'd1, 12'd1));
    step();
    chk("R7 full again", 64'(fifo_full_o), 64'd1);
    accept_i = 1; evt_num_i = 20'h66666; bx_num_i = 12'h666;
    step();
    accept_i = 0; fifo_rd_i = 1;
    chk("R7 late read drop", 64'(drop_count_o), 64'd4);
    chk("R7 late read no wr", 64'(fifo_wr_o), 64'd0);
    step();
    fifo_rd_i = 0;
    chk("R7 one freed", 64'(fifo_full_o), 64'd0);
    accept_i = 1; evt_num_i = 20'h77777; bx_num_i = 12'h777;
    step();
    accept_i = 0;
    step();
    chk("R6 refilled", 64'(fifo_full_o), 64'd1);
  endtask

  task automatic t_clear();
    drop_clr_i = 1; step(); drop_clr_i = 0;
    chk("R9 cleared", 64'(drop_count_o), 64'd0);
    drop_clr_i = 1; accept_i = 1; step(); drop_clr_i = 0; accept_i = 0;
    chk("R9 clear beats drop", 64'(drop_count_o), 64'd0);
  endtask

  task automatic t_saturate();
    accept_i = 1;
    for (int i = 0; i < 65540; i++) step();
    accept_i = 0;
    chk("R8 saturated", 64'(drop_count_o), 64'd65535);
    step();
    chk("R8 holds", 64'(drop_count_o), 64'd65535);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_idle();
    t_burst();
    t_fill();
    t_same_cycle();
    t_clear();
    t_saturate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule